// File: doc/BRIEF.md
# Key-Gated Indexed Register Port

This block exposes a bank of 8-bit configuration registers to an I/O bus through two port addresses. Writing the first port loads an index register. Reading or writing the second port reaches the register that the index currently selects. Both ports are decoded at full address width. Read data is combinational: it follows the address, the read strobe and the stored state in the same cycle. Writes take effect on the rising clock edge at which the write strobe is high.

The registers fall into three groups:
- **Compatible group:** indices 0x00 to 0x04 and 0x06. These can be written and read at any time.
- **Key register:** index 0x05. Writing the key value 0x86 there opens the extended group. Writing any other value closes it again. Reading index 0x05 never returns the stored byte. It returns an identification code whose value depends on the lock state: bits 4:0 carry an identification field and bits 7:5 carry a version field.
- **Extended group:** indices 0x07 to 0x0E. These are guarded by the key register.

All register contents and the open flag are exported so that neighbouring logic can use them directly.

Top module: `idx_port_lock`

## Requirements
- R1: A write strobe with `io_addr` = 0x3C4 loads `io_wdata` into the index register on that clock edge. A read strobe at 0x3C4 returns the index.
- R2: A read or write strobe with `io_addr` = 0x3C5 reaches the register selected by the current index.
- R3: After reset the index is 0x00. Every register is 0x00, and the extended group is closed (`ext_open` = 0).
- R4: Writing 0x86 to index 0x05 sets `ext_open` from the next cycle on.
- R5: Writing any value other than 0x86 to index 0x05 clears `ext_open` from the next cycle on.
- R6: Reading index 0x05 returns the byte formed by version field 3'b000 and identification field 5'b01011 (0x0B) while open. While closed it returns version field 3'b111 and identification field 5'b10100 (0xF4).
- R7: The compatible registers at indices 0x00 to 0x04 and 0x06 take writes and return their contents regardless of `ext_open`. Register k is exported on `cmp_q[8k+7:8k]`. Slot 5 of `cmp_q` is always 0x00.
- R8: While closed, writes to indices 0x07 to 0x0E leave `ext_q` unchanged, and reads of those indices return 0x00.
- R9: While open, indices 0x07 to 0x0E take writes and return their contents. Index 0x07+j is exported on `ext_q[8j+7:8j]`.
- R10: Indices 0x0F to 0xFF hold nothing. Writes to them change no state, and reads of them return 0x00.
- R11: Accesses to any other I/O address change no state. `io_rdata` is 0x00 whenever `io_rd` is low or the address is neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, combinational |
| ext_open | output | 1 | Extended group is unlocked |
| cmp_q | output | 56 | Compatible register contents, 8 bits per index |
| ext_q | output | 64 | Extended register contents, 8 bits per offset |

## Verification
The bound checker covers the following on every cycle:
- index loading;
- the open and close transitions caused by key-register writes;
- the identification code returned for index 0x05;
- the freezing of the extended group while closed;
- the absence of state change on foreign addresses;
- zero read data without a read strobe.

Only the bench's scenarios can show the contents returned for each compatible and extended index, the effect of near-miss key values, and the reset state. They also show that unmapped indices hold nothing and that compatible registers stay writable across repeated lock and unlock sequences. The bench does this by comparing against its own reference model on every clock.

// File: rtl/idx_port_lock.sv
module idx_port_lock #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] PORT_INDEX = 16'h03C4,
  parameter logic [15:0] PORT_DATA  = 16'h03C5,
  parameter logic [7:0]  LOCK_IDX   = 8'h05,
  parameter logic [7:0]  KEY        = 8'h86,
  parameter logic [7:0]  ID_OPEN    = 8'h0B,
  parameter logic [7:0]  ID_SHUT    = 8'hF4,
  parameter int unsigned CMP_N      = 7,
  parameter logic [7:0]  EXT_BASE   = 8'h07,
  parameter int unsigned EXT_N      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [7:0]           io_wdata,
  input  logic                 io_rd,
  input  logic                 io_wr,
  output logic [7:0]           io_rdata,
  output logic                 ext_open,
  output logic [CMP_N*8-1:0]   cmp_q,
  output logic [EXT_N*8-1:0]   ext_q
);
  localparam int unsigned CMP_SW = (CMP_N > 1) ? $clog2(CMP_N) : 1;
  localparam int unsigned EXT_SW = (EXT_N > 1) ? $clog2(EXT_N) : 1;
  localparam int unsigned CMP_PW = (1 << CMP_SW) * 8;
  localparam int unsigned EXT_PW = (1 << EXT_SW) * 8;
  localparam logic [8:0]  CMP_TOP = 9'(CMP_N);
  localparam logic [8:0]  EXT_LO  = 9'(EXT_BASE);
  localparam logic [8:0]  EXT_HI  = 9'(int'(EXT_BASE) + EXT_N);

  logic [7:0] index_q;
  logic       hit_idx, hit_dat, wr_idx, wr_dat;
  logic       sel_lock, sel_cmp, sel_ext;
  logic [8:0] idx9;
  logic [EXT_SW-1:0] ext_off;
  logic [CMP_PW-1:0] cmp_pad;
  logic [EXT_PW-1:0] ext_pad;
  logic [7:0] rd_val;

  assign hit_idx = (io_addr == ADDR_W'(PORT_INDEX));
  assign hit_dat = (io_addr == ADDR_W'(PORT_DATA));
  assign wr_idx  = io_wr && hit_idx;
  assign wr_dat  = io_wr && hit_dat;

  assign idx9     = {1'b0, index_q};
  assign sel_lock = (index_q == LOCK_IDX);
  assign sel_cmp  = (idx9 < CMP_TOP) && !sel_lock;
  assign sel_ext  = (idx9 >= EXT_LO) && (idx9 < EXT_HI);
  assign ext_off  = EXT_SW'(index_q - EXT_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      index_q <= 8'h00;
    else if (wr_idx) index_q <= io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ext_open <= 1'b0;
    else if (wr_dat && sel_lock) ext_open <= (io_wdata == KEY);
  end

  for (genvar i = 0; i < int'(CMP_N); i++) begin : g_cmp
    if (i == int'(LOCK_IDX)) begin : g_hole
      assign cmp_q[i*8 +: 8] = 8'h00;
    end else begin : g_reg
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               r <= 8'h00;
        else if (wr_dat && index_q == 8'(i))      r <= io_wdata;
      end
      assign cmp_q[i*8 +: 8] = r;
    end
  end

  for (genvar j = 0; j < int'(EXT_N); j++) begin : g_ext
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                  r <= 8'h00;
      else if (wr_dat && ext_open && sel_ext && ext_off == EXT_SW'(j)) r <= io_wdata;
    end
    assign ext_q[j*8 +: 8] = r;
  end

  assign cmp_pad = CMP_PW'(cmp_q);
  assign ext_pad = EXT_PW'(ext_q);

  always_comb begin
    rd_val = 8'h00;
    if (sel_lock)
      rd_val = ext_open ? ID_OPEN : ID_SHUT;
    else if (sel_cmp)
      rd_val = cmp_pad[index_q[CMP_SW-1:0]*8 +: 8];
    else if (sel_ext && ext_open)
      rd_val = ext_pad[ext_off*8 +: 8];
  end

  assign io_rdata = !io_rd  ? 8'h00 :
                    hit_idx ? index_q :
                    hit_dat ? rd_val  : 8'h00;
endmodule

// File: rtl/idx_port_lock_chk.sv
module idx_port_lock_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] PORT_INDEX = 16'h03C4,
  parameter logic [15:0] PORT_DATA  = 16'h03C5,
  parameter logic [7:0]  LOCK_IDX   = 8'h05,
  parameter logic [7:0]  KEY        = 8'h86,
  parameter logic [7:0]  ID_OPEN    = 8'h0B,
  parameter logic [7:0]  ID_SHUT    = 8'hF4,
  parameter int unsigned CMP_N      = 7,
  parameter int unsigned EXT_N      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  io_addr,
  input logic [7:0]         io_wdata,
  input logic               io_rd,
  input logic               io_wr,
  input logic [7:0]         io_rdata,
  input logic               ext_open,
  input logic [CMP_N*8-1:0] cmp_q,
  input logic [EXT_N*8-1:0] ext_q,
  input logic [7:0]         index_q
);
  logic at_idx, at_dat, foreign;
  assign at_idx  = (io_addr == ADDR_W'(PORT_INDEX));
  assign at_dat  = (io_addr == ADDR_W'(PORT_DATA));
  assign foreign = !at_idx && !at_dat;

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_idx |=> index_q == $past(io_wdata));

  // R4
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_dat && index_q == LOCK_IDX && io_wdata == KEY |=> ext_open);

  // R5
  other_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && at_dat && index_q == LOCK_IDX && io_wdata != KEY |=> !ext_open);

  // R6
  ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && at_dat && index_q == LOCK_IDX |-> io_rdata == (ext_open ? ID_OPEN : ID_SHUT));

  // R8
  closed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_open |=> $stable(ext_q));

  // R11
  foreign_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    foreign |=> $stable(index_q) && $stable(ext_open) && $stable(cmp_q) && $stable(ext_q));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd || foreign |-> io_rdata == 8'h00);

  // R7
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q[int'(LOCK_IDX)*8 +: 8] == 8'h00);
endmodule

bind idx_port_lock idx_port_lock_chk #(
  .ADDR_W(ADDR_W), .PORT_INDEX(PORT_INDEX), .PORT_DATA(PORT_DATA),
  .LOCK_IDX(LOCK_IDX), .KEY(KEY), .ID_OPEN(ID_OPEN), .ID_SHUT(ID_SHUT),
  .CMP_N(CMP_N), .EXT_N(EXT_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .ext_open(ext_open),
  .cmp_q(cmp_q), .ext_q(ext_q), .index_q(index_q)
);

// File: tb/idx_port_lock_test.sv
module idx_port_lock_test;
  localparam int PERIOD = 10;
  localparam logic [15:0] PI = 16'h03C4, PD = 16'h03C5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        ext_open;
  logic [55:0] cmp_q;
  logic [63:0] ext_q;

  int vectors = 0, fails = 0;
  bit done = 0;

  int m_idx;
  bit m_open;
  int m_reg [256];

  idx_port_lock uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .ext_open(ext_open),
    .cmp_q(cmp_q), .ext_q(ext_q)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int m_read(input logic [15:0] a, input bit rd);
    if (!rd) return 0;
    if (a == PI) return m_idx;
    if (a != PD) return 0;
    if (m_idx == 5) return m_open ? 'h0B : 'hF4;
    if (m_idx < 7) return m_reg[m_idx];
    if (m_idx < 15) return m_open ? m_reg[m_idx] : 0;
    return 0;
  endfunction

  function automatic logic [55:0] m_cmp();
    logic [55:0] v = '0;
    for (int i = 0; i < 7; i++) if (i != 5) v[i*8 +: 8] = 8'(m_reg[i]);
    return v;
  endfunction

  function automatic logic [63:0] m_ext();
    logic [63:0] v = '0;
    for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'(m_reg[7+j]);
    return v;
  endfunction

  task automatic reset_model();
    m_idx = 0; m_open = 0;
    for (int i = 0; i < 256; i++) m_reg[i] = 0;
  endtask

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input bit rd, input bit wr, input string tag);
    logic [7:0] er;
    io_addr = a; io_wdata = d; io_rd = rd; io_wr = wr;
    #1;
    er = 8'(m_read(a, rd));
    vectors++;
    if (io_rdata !== er || ext_open !== m_open || cmp_q !== m_cmp() || ext_q !== m_ext()) begin
      fails++;
      $display("FAIL %s: rdata=%h exp %h open=%b exp %b cmp=%h exp %h ext=%h exp %h",
               tag, io_rdata, er, ext_open, m_open, cmp_q, m_cmp(), ext_q, m_ext());
    end
    @(posedge clk);
    if (wr) begin
      if (a == PI) m_idx = int'(d);
      else if (a == PD) begin
        if (m_idx == 5) m_open = (d == 8'h86);
        else if (m_idx < 7) m_reg[m_idx] = int'(d);
        else if (m_idx < 15 && m_open) m_reg[m_idx] = int'(d);
      end
    end
    @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] d, input string tag);
    cyc(PI, idx, 0, 1, tag);
    cyc(PD, d, 0, 1, tag);
  endtask

  task automatic rreg(input logic [7:0] idx, input string tag);
    cyc(PI, idx, 0, 1, tag);
    cyc(PD, 8'h00, 1, 0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
  end

  initial begin
    reset_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state
    cyc(PI, 8'h00, 1, 0, "R3");
    cyc(PD, 8'h00, 1, 0, "R3");
    // R1: index load and readback
    cyc(PI, 8'h5A, 0, 1, "R1");
    cyc(PI, 8'h00, 1, 0, "R1");
    // R6: closed identification
    rreg(8'h05, "R6");
    // R7: compatible registers while closed, including index 6
    for (int i = 0; i < 7; i++) if (i != 5) wreg(8'(i), 8'(8'h30 + i), "R7");
    for (int i = 0; i < 7; i++) rreg(8'(i), "R7");
    // R8: closed extended writes ignored, reads zero
    wreg(8'h07, 8'hAA, "R8");
    wreg(8'h0E, 8'hBB, "R8");
    rreg(8'h07, "R8");
    // R4: unlock, then R6 open identification
    wreg(8'h05, 8'h86, "R4");
    cyc(PD, 8'h00, 1, 0, "R6");
    // R9: extended group open
    for (int j = 0; j < 8; j++) wreg(8'(7 + j), 8'(8'hC0 + j), "R9");
    for (int j = 0; j < 8; j++) rreg(8'(7 + j), "R9");
    // R2: rapid index change between data accesses
    rreg(8'h06, "R2");
    rreg(8'h0E, "R2");
    // R5: close with near-miss values
    wreg(8'h05, 8'h87, "R5");
    rreg(8'h0A, "R5");
    wreg(8'h0A, 8'h11, "R8");
    rreg(8'h05, "R6");
    wreg(8'h05, 8'h86, "R4");
    wreg(8'h05, 8'h00, "R5");
    wreg(8'h05, 8'h86, "R4");
    wreg(8'h05, 8'h06, "R5");
    // R7: compatible still writable after lock cycling
    wreg(8'h06, 8'h77, "R7");
    rreg(8'h06, "R7");
    // R10: unmapped indices
    wreg(8'h0F, 8'h99, "R10");
    rreg(8'h0F, "R10");
    wreg(8'hFF, 8'h98, "R10");
    rreg(8'hFF, "R10");
    // R11: foreign addresses and missing read strobe
    cyc(16'h03C3, 8'h86, 1, 1, "R11");
    cyc(16'h03C6, 8'h12, 1, 1, "R11");
    cyc(16'h13C4, 8'h12, 1, 1, "R11");
    cyc(PD, 8'h00, 0, 0, "R11");
    cyc(PI, 8'h00, 0, 0, "R11");
    // R2: mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [15:0] a;
      logic [7:0] d;
      case (sel)
        0, 1:    a = PI;
        2, 3, 4, 5, 6: a = PD;
        7:       a = 16'h03C3;
        8:       a = 16'h03C6;
        default: a = 16'($urandom);
      endcase
      d = 8'($urandom);
      if (a == PI && $urandom_range(0, 3) != 0) d = 8'($urandom_range(0, 16));
      if (a == PD && m_idx == 5 && $urandom_range(0, 1) == 0) d = 8'h86;
      cyc(a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R2");
    end
    summary();
  end
endmodule